// File: doc/BRIEF.md
# Recurrent Network Fitness Evaluator

This block scores one candidate weight set for a small recurrent network in which every neuron is connected to every other neuron. A packed chromosome is loaded through a write port and holds one signed-fraction weight for each ordered neuron pair. When a run is started, all neuron outputs start at zero. The network then steps through a fixed number of ticks. On each tick, every neuron adds up its weighted inputs from all neurons, including its own output, and adds an external bias. It then squashes that sum with A/(|A|+1), using a multi-cycle restoring divider. All neurons update together.

On every tick, one designated neuron is compared with a target value. The squared difference goes into a saturating accumulator. A smaller final sum marks a fitter candidate. A search engine outside this block loads a chromosome, pulses start, waits for done and reads the error sum.

Default configuration: 3 neurons, 4 magnitude bits per weight, 8 fractional bits for signals, 15 ticks, and neuron 2 as the output.

Top module: `nn_fitness_eval`

## Requirements
- R1: After reset, busy and done are 0 and err_sum is 0.
- R2: Gene g = j*N + i holds the weight from neuron i into neuron j. It occupies chrom_data bits [g*(P+1) +: P+1]. The top bit of the gene is the sign (1 = negative) and the lower P bits are the magnitude m. The weight value is ±m/2^P.
- R3: On each tick the activation of neuron j is the sum over all i (self included) of W(j,i)*S(i), plus E(j). The S values are the previous tick's outputs. All outputs are zero before the first tick.
- R4: Signals are signed two's complement with FW fractional bits. The new output is sign(A)·floor(|A|·2^FW / (|A| + 2^(FW+P))), where A is the activation carried with FW+P fractional bits.
- R5: On each of the TICKS ticks, (target − S_out)^2 is added to err_sum, where S_out is the freshly updated output neuron. The square is carried with 2·FW fractional bits.
- R6: err_sum saturates at 2^ERR_W − 1 and never wraps.
- R7: done is a single-cycle pulse that appears TICKS·(FW+2)+1 cycles after start is accepted. busy is high from acceptance until done. err_sum is final when done is high.
- R8: A chromosome write while busy is ignored. Neither the running score nor later runs see it.
- R9: start while busy is ignored. No extra run and no extra done pulse follow.
- R10: target and ext_in are sampled when start is accepted. Between runs, err_sum holds its value whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chrom_we | input | 1 | Chromosome write strobe, taken only while idle |
| chrom_data | input | N*N*(P+1) | Packed chromosome |
| target | input | FW+2 | Signed target value, FW fractional bits |
| ext_in | input | N*(FW+2) | Per-neuron signed external inputs, neuron 0 in the low bits |
| start | input | 1 | Begin an evaluation (taken only while idle) |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_sum | output | ERR_W | Saturated sum of squared errors |

## Verification
Each tick costs FW+2 cycles: one to form the activations, FW divider steps, and one to update the outputs and the error sum. done is therefore due exactly TICKS·(FW+2)+1 cycles after the edge that accepts start. The bench drives inputs and samples outputs on falling edges. It counts rising edges from the accepting edge until done is seen, and compares that count and err_sum against a bit-exact integer model of R2 to R6. The hold and ignore checks read err_sum and done after a known number of quiet cycles.

// File: rtl/nn_eval_pkg.sv
package nn_eval_pkg;
  typedef enum logic [2:0] {
    EV_IDLE,
    EV_ACT,
    EV_DIV,
    EV_UPD,
    EV_FIN
  } ev_state_t;
endpackage

// File: rtl/nn_activation.sv
module nn_activation #(
  parameter int N  = 3,
  parameter int P  = 4,
  parameter int SW = 10,
  parameter int AW = 17
) (
  input  logic [N*N*(P+1)-1:0] chrom,
  input  logic [N*SW-1:0]      s_vec,
  input  logic [N*SW-1:0]      ext_vec,
  output logic [N*AW-1:0]      act_vec
);
  for (genvar j = 0; j < N; j++) begin : g_neuron
    logic signed [AW-1:0] sum;
    logic signed [AW-1:0] term;
    logic [P:0]           gene;
    always_comb begin
      sum  = AW'($signed(ext_vec[j*SW +: SW])) <<< P;
      term = '0;
      gene = '0;
      for (int i = 0; i < N; i++) begin
        gene = chrom[(j*N+i)*(P+1) +: (P+1)];
        term = AW'($signed({1'b0, gene[P-1:0]})) * AW'($signed(s_vec[i*SW +: SW]));
        if (gene[P]) sum = sum - term;
        else         sum = sum + term;
      end
    end
    assign act_vec[j*AW +: AW] = sum;
  end
endmodule

// File: rtl/nn_squash_div.sv
module nn_squash_div #(
  parameter int AW = 17,
  parameter int FW = 8,
  parameter int P  = 4,
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] act,
  output logic [SW-1:0] s_out
);
  localparam int F = FW + P;
  localparam logic [AW+1:0] ONE_F = (AW+2)'(1) << F;

  logic          neg_q;
  logic [AW+1:0] rem_q, den_q, rem_sh;
  logic [FW-1:0] quo_q;
  logic [AW-1:0] mag;

  assign mag    = act[AW-1] ? AW'(-$signed(act)) : act;
  assign rem_sh = rem_q << 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q <= 1'b0;
      rem_q <= '0;
      den_q <= '0;
      quo_q <= '0;
    end else if (load) begin
      neg_q <= act[AW-1];
      rem_q <= (AW+2)'(mag);
      den_q <= (AW+2)'(mag) + ONE_F;
      quo_q <= '0;
    end else if (step) begin
      if (rem_sh >= den_q) begin
        rem_q <= rem_sh - den_q;
        quo_q <= {quo_q[FW-2:0], 1'b1};
      end else begin
        rem_q <= rem_sh;
        quo_q <= {quo_q[FW-2:0], 1'b0};
      end
    end
  end

  assign s_out = neg_q ? SW'(-$signed(SW'(quo_q))) : SW'(quo_q);
endmodule

// File: rtl/nn_err_acc.sv
module nn_err_acc #(
  parameter int SW    = 10,
  parameter int ERR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [SW-1:0]    tgt,
  input  logic [SW-1:0]    s_cur,
  output logic [ERR_W-1:0] err
);
  localparam int SQW  = 2 * (SW + 1);
  localparam int SUMW = ((ERR_W > SQW) ? ERR_W : SQW) + 1;
  localparam logic [SUMW-1:0] MAXV = SUMW'({ERR_W{1'b1}});

  logic signed [SW:0] diff;
  logic [SW:0]        adiff;
  logic [SQW-1:0]     sq;
  logic [SUMW-1:0]    sum;

  assign diff  = $signed({tgt[SW-1], tgt}) - $signed({s_cur[SW-1], s_cur});
  assign adiff = diff[SW] ? SW'(-diff) : SW'(diff);
  assign sq    = SQW'(adiff) * SQW'(adiff);
  assign sum   = SUMW'(err) + SUMW'(sq);

  always_ff @(posedge clk) begin
    if (rst || clr)       err <= '0;
    else if (en) begin
      if (sum > MAXV)     err <= {ERR_W{1'b1}};
      else                err <= sum[ERR_W-1:0];
    end
  end
endmodule

// File: rtl/nn_fitness_eval.sv
module nn_fitness_eval #(
  parameter int N       = 3,
  parameter int P       = 4,
  parameter int FW      = 8,
  parameter int TICKS   = 15,
  parameter int OUT_IDX = N - 1,
  parameter int ERR_W   = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chrom_we,
  input  logic [N*N*(P+1)-1:0]    chrom_data,
  input  logic [FW+1:0]           target,
  input  logic [N*(FW+2)-1:0]     ext_in,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic [ERR_W-1:0]        err_sum
);
  import nn_eval_pkg::*;

  localparam int CW   = N * N * (P + 1);
  localparam int SW   = FW + 2;
  localparam int AW   = FW + P + $clog2(N + 2) + 2;
  localparam int CNTW = $clog2(FW + 1);
  localparam int TW   = $clog2(TICKS + 1);

  ev_state_t       state;
  logic [CW-1:0]   chrom_q;
  logic [SW-1:0]   tgt_q;
  logic [N*SW-1:0] ext_q, s_q, s_new;
  logic [N*AW-1:0] act_vec;
  logic [CNTW-1:0] div_cnt;
  logic [TW-1:0]   tick;
  logic            busy_q, done_q, accept;

  assign accept = (state == EV_IDLE) && start;

  nn_activation #(.N(N), .P(P), .SW(SW), .AW(AW)) u_act (
    .chrom(chrom_q), .s_vec(s_q), .ext_vec(ext_q), .act_vec(act_vec)
  );

  for (genvar j = 0; j < N; j++) begin : g_div
    nn_squash_div #(.AW(AW), .FW(FW), .P(P), .SW(SW)) u_div (
      .clk(clk), .rst(rst),
      .load(state == EV_ACT), .step(state == EV_DIV),
      .act(act_vec[j*AW +: AW]), .s_out(s_new[j*SW +: SW])
    );
  end

  nn_err_acc #(.SW(SW), .ERR_W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .clr(accept), .en(state == EV_UPD),
    .tgt(tgt_q), .s_cur(s_new[OUT_IDX*SW +: SW]), .err(err_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= EV_IDLE;
      chrom_q <= '0;
      tgt_q   <= '0;
      ext_q   <= '0;
      s_q     <= '0;
      div_cnt <= '0;
      tick    <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        EV_IDLE: begin
          if (chrom_we) chrom_q <= chrom_data;
          if (start) begin
            tgt_q  <= target;
            ext_q  <= ext_in;
            s_q    <= '0;
            tick   <= '0;
            busy_q <= 1'b1;
            state  <= EV_ACT;
          end
        end
        EV_ACT: begin
          div_cnt <= '0;
          state   <= EV_DIV;
        end
        EV_DIV: begin
          if (div_cnt == CNTW'(FW - 1)) state <= EV_UPD;
          else                          div_cnt <= div_cnt + 1'b1;
        end
        EV_UPD: begin
          s_q <= s_new;
          if (tick == TW'(TICKS - 1)) state <= EV_FIN;
          else begin
            tick  <= tick + 1'b1;
            state <= EV_ACT;
          end
        end
        EV_FIN: begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
          state  <= EV_IDLE;
        end
        default: state <= EV_IDLE;
      endcase
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/nn_fitness_eval_chk.sv
module nn_fitness_eval_chk #(
  parameter int FW    = 8,
  parameter int TICKS = 15,
  parameter int ERR_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [ERR_W-1:0] err_sum
);
  localparam int LAT = TICKS * (FW + 2) + 1;

  logic [31:0] since;
  logic        run;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      run   <= 1'b0;
    end else if (!busy && start) begin
      since <= '0;
      run   <= 1'b1;
    end else if (run) begin
      since <= since + 1;
      if (done) run <= 1'b0;
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> (run && since == LAT));
  a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    busy |=> (err_sum >= $past(err_sum)));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(err_sum));
endmodule

bind nn_fitness_eval nn_fitness_eval_chk #(.FW(FW), .TICKS(TICKS), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .err_sum(err_sum)
);

// File: tb/sim_nn_fitness_eval.sv
module sim_nn_fitness_eval;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3, P = 4, FW = 8, TK = 15, OUTN = 2, EW = 24, EW1 = 10;
  localparam int SW = FW + 2;
  localparam int CW = N * N * (P + 1);
  localparam int LAT = TK * (FW + 2) + 1;
  localparam int NV = 6;

  localparam logic [CW-1:0] CH_T [NV] = '{45'h0, 45'h1FFF_FFFF_FFFF, 45'h0842_1084_2108,
                                          45'h1234_5678_9ABC, 45'h0F0F_0F0F_0F0F, 45'h1555_5555_5555};
  localparam logic [N*SW-1:0] EX_T [NV] = '{
    {10'd0, 10'd0, 10'd0},
    {10'd128, 10'd128, 10'd128},
    {10'(-200), 10'd64, 10'd300},
    {10'd0, 10'(-256), 10'd100},
    {10'(-128), 10'(-128), 10'(-128)},
    {10'd511, 10'(-512), 10'd50}};
  localparam int TG_T [NV] = '{144, 144, 144, -100, 144, -300};

  logic clk = 0, rst = 1, chrom_we = 0, start = 0, start1 = 0;
  logic [CW-1:0] chrom_data = '0;
  logic [SW-1:0] target = '0;
  logic [N*SW-1:0] ext_in = '0;
  logic busy, done, busy1, done1;
  logic [EW-1:0] err_sum;
  logic [EW1-1:0] err1;
  int checks = 0, failures = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nn_fitness_eval u0 (.clk(clk), .rst(rst), .chrom_we(chrom_we), .chrom_data(chrom_data),
    .target(target), .ext_in(ext_in), .start(start), .busy(busy), .done(done), .err_sum(err_sum));

  nn_fitness_eval #(.ERR_W(EW1)) u1 (.clk(clk), .rst(rst), .chrom_we(chrom_we), .chrom_data(chrom_data),
    .target(target), .ext_in(ext_in), .start(start1), .busy(busy1), .done(done1), .err_sum(err1));

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Integer model of R2..R6
  function automatic longint model(input logic [CW-1:0] ch, input logic [N*SW-1:0] ex,
                                   input int tgt, input int ew);
    int s [N];
    int sn [N];
    longint acc = 0;
    longint mx = (longint'(1) << ew) - 1;
    for (int j = 0; j < N; j++) s[j] = 0;
    for (int t = 0; t < TK; t++) begin
      for (int j = 0; j < N; j++) begin
        int a = int'($signed(ex[j*SW +: SW])) * (1 << P);
        int mag, q;
        for (int i = 0; i < N; i++) begin
          logic [P:0] g = ch[(j*N+i)*(P+1) +: (P+1)];
          int m = int'(g[P-1:0]);
          if (g[P]) a = a - m * s[i];
          else      a = a + m * s[i];
        end
        mag = (a < 0) ? -a : a;
        q = (mag * (1 << FW)) / (mag + (1 << (FW + P)));
        sn[j] = (a < 0) ? -q : q;
      end
      for (int j = 0; j < N; j++) s[j] = sn[j];
      acc = acc + longint'(tgt - s[OUTN]) * longint'(tgt - s[OUTN]);
      if (acc > mx) acc = mx;
    end
    return acc;
  endfunction

  task automatic run(input logic [CW-1:0] ch, input logic [N*SW-1:0] ex, input int tgt,
                     input bit load, input bit disturb, output longint err_o, output int lat_o);
    int k;
    if (load) begin
      @(negedge clk); chrom_we = 1; chrom_data = ch;
      @(negedge clk); chrom_we = 0;
    end
    @(negedge clk); target = SW'(tgt); ext_in = ex; start = 1;
    @(negedge clk); start = 0;
    k = 0;
    while (!done && k < 2000) begin
      if (disturb && k == 20) begin
        chrom_we = 1; chrom_data = ~ch; start = 1; target = SW'(-tgt); ext_in = ~ex;
      end
      if (k == 21) begin chrom_we = 0; start = 0; end
      @(negedge clk);
      k++;
    end
    err_o = err_sum;
    lat_o = k;
  endtask

  initial begin
    longint e, hold;
    int lat, extra;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err_sum", err_sum, 0);
    check("R1 err_sum u1", err1, 0);
    rst = 0;

    // Table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      run(CH_T[v], EX_T[v], TG_T[v], 1, 0, e, lat);
      check($sformatf("R5 vector %0d err", v), e, model(CH_T[v], EX_T[v], TG_T[v], EW));
      check($sformatf("R7 vector %0d latency", v), lat, LAT);
      if (v == 0) begin
        @(negedge clk);
        check("R7 done one cycle", done, 0);
        check("R7 busy low after", busy, 0);
      end
    end

    // R8 R9: disturbances during a run
    run(CH_T[2], EX_T[2], TG_T[2], 1, 1, e, lat);
    check("R8 R10 disturbed err", e, model(CH_T[2], EX_T[2], TG_T[2], EW));
    check("R9 latency from first start", lat, LAT);
    extra = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    check("R9 no second run", extra, 0);

    // R8: chromosome from before the disturbed run is still in place
    run(CH_T[2], EX_T[2], TG_T[2], 0, 0, e, lat);
    check("R8 chromosome kept", e, model(CH_T[2], EX_T[2], TG_T[2], EW));

    // R10: hold between runs
    hold = err_sum;
    target = SW'(-400); ext_in = ~EX_T[2]; chrom_we = 1; chrom_data = CH_T[5];
    repeat (30) @(negedge clk);
    chrom_we = 0;
    check("R10 err_sum held", err_sum, hold);

    // R6: saturation on a narrow accumulator
    @(negedge clk); chrom_we = 1; chrom_data = CH_T[1];
    @(negedge clk); chrom_we = 0; target = SW'(-512); ext_in = EX_T[1]; start1 = 1;
    @(negedge clk); start1 = 0;
    for (int c = 0; c < 2000 && !done1; c++) @(negedge clk);
    check("R6 saturated", err1, (longint'(1) << EW1) - 1);
    check("R6 model agrees", model(CH_T[1], EX_T[1], -512, EW1), (longint'(1) << EW1) - 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule